// File: doc/BRIEF.md
# Protected Memory Set with Check-Bit Error Injection

This block groups three small on-chip stores, each guarded by its own check code. The counter store has 64 words of 32 data bits. Each word carries an 8-bit single-error-correct, double-error-detect code. That code is computed as if the data were zero-extended to 64 bits. The filter store has 128 words of 32 bits and keeps one parity bit per byte. The flex store has 128 words. Each flex word holds a 32-bit value with byte parity and a 4-bit mask covered by one extra parity bit. All three stores share one synchronous port. A select field picks the target store, and a read returns its word one clock later.

A test register arms a one-shot fault. It names one store and gives an XOR mask. On the next write to that store, the mask is applied to the computed check bits, and the data is stored unchanged. The fault is only found when that entry is read back. Detected faults set sticky cause bits, and an interrupt is raised when a set cause bit is also enabled. After reset, a scrub sequencer writes zero, with valid check bits, to every address of all three stores. Functional accesses are held off until the scrub has finished.

Top module: `protMemSet`

## Requirements
- R1: While reset is asserted, scrubDone, injArmed, causeBits and irq are all 0. After reset is released, scrubDone rises exactly 128 cycles later and then stays high. A read issued before scrubDone is high produces no rdValid.
- R2: Once the scrub has finished, every entry of every store reads back as zero data, with mask zero and rdErr zero.
- R3: memSel encodes the target store: 0 is the counter store, 1 is the filter store and 2 is the flex store. A read presented in one cycle gives rdValid together with the stored data in the next cycle. rdFmask returns the flex mask and reads as 0 for the other two stores.
- R4: A counter-store word whose check bits differ from the valid code in exactly one bit reads back with the original data and sets rdErr[0] (correctable). Examples are injection masks 0x01, 0x40 and 0x80.
- R5: A counter-store word with two check bits flipped, for example injection mask 0x03, sets rdErr[1] (uncorrectable). rdErr[0] and rdErr[1] are never set together.
- R6: On the filter store, an injection mask in bits 3..0 flips the parity bit of the matching byte. Reading that word sets rdErr[2] and returns the stored data uncorrected.
- R7: On the flex store, mask bits 3..0 flip the byte parity bits and mask bit 4 flips the parity bit of the 4-bit mask field. Either kind of flip sets rdErr[3] on read.
- R8: A testWr pulse loads testSel and testMask and sets injArmed. The mask applies only to the next write to the selected store. Writes to other stores leave injArmed set and are stored clean. After the consuming write, injArmed is 0 and later writes are clean, so rewriting a corrupted entry clears its fault.
- R9: A write that carries an injected fault changes no cause bit.
- R10: causeBits latch rdErr in the cycle after rdValid and stay set until the matching causeClr bit is pulsed. When a clear and a new detection for the same bit fall in the same cycle, the bit stays set.
- R11: irq is high exactly when some bit is set in both causeBits and intEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memSel | input | 2 | Target store: 0 counter, 1 filter, 2 flex, 3 none |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 7 | Word address (counter store uses bits 5..0) |
| wrData | input | 32 | Write data |
| wrFmask | input | 4 | Mask field written into the flex store |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Read data (ECC-corrected for the counter store) |
| rdFmask | output | 4 | Flex mask field from the read |
| rdErr | output | 4 | Per-read fault flags: 0 corrected, 1 uncorrectable, 2 filter parity, 3 flex parity |
| testWr | input | 1 | Loads the test register and arms injection |
| testSel | input | 2 | Store that receives the injected fault |
| testMask | input | 8 | XOR mask applied to the check bits |
| injArmed | output | 1 | Injection armed and not yet consumed |
| causeClr | input | 4 | Write-one-to-clear for cause bits |
| intEn | input | 4 | Interrupt enable per cause bit |
| causeBits | output | 4 | Sticky fault causes, same positions as rdErr |
| irq | output | 1 | Interrupt request |
| scrubDone | output | 1 | Scrub sequence finished |

## Verification
Two things can land on the same clock edge. One is a fault detection setting a cause bit. The other is software clearing that same bit. The bench provokes this by setting the filter cause bit, re-injecting a parity fault and issuing the read, then pulsing causeClr for that bit in the cycle where rdValid is high, so both act on the same edge. A correct design keeps the bit set, and a following lone clear drops it.

// File: rtl/protMemPkg.sv
package protMemPkg;
  localparam int DataW    = 32;
  localparam int EccW     = 8;
  localparam int HamW     = 7;
  localparam int PadW     = 64;
  localparam int ByteN    = DataW / 8;
  localparam int FmaskW   = 4;
  localparam int AddrW    = 7;
  localparam int NumMem   = 3;
  localparam int NumCause = 4;

  localparam int IdxCnt  = 0;
  localparam int IdxFilt = 1;
  localparam int IdxFlex = 2;

  localparam int CauseCorr = 0;
  localparam int CauseUnc  = 1;
  localparam int CauseFilt = 2;
  localparam int CauseFlex = 3;

  typedef struct packed {
    logic [NumMem-1:0] wr;
    logic [NumMem-1:0] rd;
    logic [AddrW-1:0]  addr;
    logic              useZero;
    logic [EccW-1:0]   inj;
  } memStrobe_t;

  typedef struct packed {
    logic [DataW-1:0] data;
    logic             corr;
    logic             uncorr;
  } eccRes_t;

  function automatic logic [HamW-1:0] hamCheck(input logic [DataW-1:0] d);
    logic [PadW-1:0] pad;
    logic [HamW-1:0] c;
    int k;
    pad = {{(PadW-DataW){1'b0}}, d};
    c = '0;
    k = 0;
    for (int p = 1; p <= PadW + HamW; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < HamW; j++)
          if (p[j]) c[j] = c[j] ^ pad[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [HamW-1:0] hamPos(input int idx);
    logic [HamW-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int p = 1; p <= PadW + HamW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == idx) r = p[HamW-1:0];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [EccW-1:0] eccEncode(input logic [DataW-1:0] d);
    logic [HamW-1:0] c;
    c = hamCheck(d);
    return {(^d) ^ (^c), c};
  endfunction

  function automatic eccRes_t eccDecode(input logic [DataW-1:0] d, input logic [EccW-1:0] c);
    eccRes_t r;
    logic [HamW-1:0] syn;
    logic parErr;
    logic found;
    syn    = hamCheck(d) ^ c[HamW-1:0];
    parErr = (^d) ^ (^c);
    found  = 1'b0;
    r.data   = d;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (syn != '0 && !parErr) begin
      r.uncorr = 1'b1;
    end else if (parErr) begin
      for (int i = 0; i < DataW; i++) begin
        if (hamPos(i) == syn) begin
          r.data[i] = ~d[i];
          found = 1'b1;
        end
      end
      if (((syn & (syn - 1'b1)) != '0) && !found) r.uncorr = 1'b1;
      else r.corr = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [ByteN-1:0] bytePar(input logic [DataW-1:0] d);
    logic [ByteN-1:0] p;
    for (int b = 0; b < ByteN; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction
endpackage

// File: rtl/protMemDatapath.sv
module protMemDatapath
  import protMemPkg::*;
#(
  parameter int CntDepth  = 64,
  parameter int FiltDepth = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  memStrobe_t          strobe,
  input  logic [DataW-1:0]    wrData,
  input  logic [FmaskW-1:0]   wrFmask,
  output logic                rdValid,
  output logic [DataW-1:0]    rdData,
  output logic [FmaskW-1:0]   rdFmask,
  output logic [NumCause-1:0] rdErr
);
  localparam int CntAW  = $clog2(CntDepth);
  localparam int FiltAW = $clog2(FiltDepth);
  localparam int CntW   = DataW + EccW;
  localparam int FiltW  = DataW + ByteN;
  localparam int FlexW  = DataW + FmaskW + ByteN + 1;

  logic [CntW-1:0]  cntMem  [CntDepth];
  logic [FiltW-1:0] filtMem [FiltDepth];
  logic [FlexW-1:0] flexMem [FiltDepth];

  logic [DataW-1:0]  dIn;
  logic [FmaskW-1:0] mIn;
  logic [CntW-1:0]   cntWord;
  logic [FiltW-1:0]  filtWord;
  logic [FlexW-1:0]  flexWord;
  logic [CntW-1:0]   cntQ;
  logic [FiltW-1:0]  filtQ;
  logic [FlexW-1:0]  flexQ;
  logic [NumMem-1:0] rdWhich;
  eccRes_t           dec;

  assign dIn      = strobe.useZero ? '0 : wrData;
  assign mIn      = strobe.useZero ? '0 : wrFmask;
  assign cntWord  = {eccEncode(dIn) ^ strobe.inj, dIn};
  assign filtWord = {bytePar(dIn) ^ strobe.inj[ByteN-1:0], dIn};
  assign flexWord = {(^mIn) ^ strobe.inj[ByteN], bytePar(dIn) ^ strobe.inj[ByteN-1:0], mIn, dIn};

  always_ff @(posedge clk) begin
    if (strobe.wr[IdxCnt])  cntMem[strobe.addr[CntAW-1:0]]   <= cntWord;
    if (strobe.wr[IdxFilt]) filtMem[strobe.addr[FiltAW-1:0]] <= filtWord;
    if (strobe.wr[IdxFlex]) flexMem[strobe.addr[FiltAW-1:0]] <= flexWord;
    if (strobe.rd[IdxCnt])  cntQ  <= cntMem[strobe.addr[CntAW-1:0]];
    if (strobe.rd[IdxFilt]) filtQ <= filtMem[strobe.addr[FiltAW-1:0]];
    if (strobe.rd[IdxFlex]) flexQ <= flexMem[strobe.addr[FiltAW-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdWhich <= '0;
    else       rdWhich <= strobe.rd;
  end

  always_comb begin
    dec     = eccDecode(cntQ[DataW-1:0], cntQ[CntW-1:DataW]);
    rdData  = '0;
    rdFmask = '0;
    rdErr   = '0;
    if (rdWhich[IdxCnt]) begin
      rdData          = dec.data;
      rdErr[CauseCorr] = dec.corr;
      rdErr[CauseUnc]  = dec.uncorr;
    end else if (rdWhich[IdxFilt]) begin
      rdData           = filtQ[DataW-1:0];
      rdErr[CauseFilt] = bytePar(filtQ[DataW-1:0]) != filtQ[FiltW-1:DataW];
    end else if (rdWhich[IdxFlex]) begin
      rdData           = flexQ[DataW-1:0];
      rdFmask          = flexQ[DataW +: FmaskW];
      rdErr[CauseFlex] = (bytePar(flexQ[DataW-1:0]) != flexQ[DataW+FmaskW +: ByteN])
                       || ((^flexQ[DataW +: FmaskW]) != flexQ[FlexW-1]);
    end
  end

  assign rdValid = |rdWhich;

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd != '0) |=> rdValid);

  // R5
  corr_unc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr[CauseCorr] |-> !rdErr[CauseUnc]);
endmodule

// File: rtl/protMemCtrl.sv
module protMemCtrl
  import protMemPkg::*;
#(
  parameter int ScrubDepth = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          memSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [AddrW-1:0]    addr,
  input  logic                testWr,
  input  logic [1:0]          testSel,
  input  logic [EccW-1:0]     testMask,
  input  logic [NumCause-1:0] causeClr,
  input  logic [NumCause-1:0] intEn,
  input  logic                rdValid,
  input  logic [NumCause-1:0] rdErr,
  output memStrobe_t          strobe,
  output logic                scrubDone,
  output logic                injArmed,
  output logic [NumCause-1:0] causeBits,
  output logic                irq
);
  localparam int ScrubAW = $clog2(ScrubDepth);

  logic [ScrubAW-1:0] scrubCnt;
  logic [1:0]         injSel;
  logic [EccW-1:0]    injMask;
  logic [NumMem-1:0]  selHot;
  logic               injHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrubCnt  <= '0;
      scrubDone <= 1'b0;
    end else if (!scrubDone) begin
      if (scrubCnt == ScrubAW'(ScrubDepth - 1)) scrubDone <= 1'b1;
      else scrubCnt <= scrubCnt + 1'b1;
    end
  end

  always_comb begin
    selHot = '0;
    for (int m = 0; m < NumMem; m++)
      if (memSel == 2'(m)) selHot[m] = 1'b1;
  end

  assign injHit = scrubDone && injArmed && wrEn && (memSel == injSel);

  always_comb begin
    if (!scrubDone) begin
      strobe.wr      = '1;
      strobe.rd      = '0;
      strobe.addr    = AddrW'(scrubCnt);
      strobe.useZero = 1'b1;
      strobe.inj     = '0;
    end else begin
      strobe.wr      = wrEn ? selHot : '0;
      strobe.rd      = rdEn ? selHot : '0;
      strobe.addr    = addr;
      strobe.useZero = 1'b0;
      strobe.inj     = injHit ? injMask : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injArmed <= 1'b0;
      injSel   <= '0;
      injMask  <= '0;
    end else if (testWr) begin
      injArmed <= 1'b1;
      injSel   <= testSel;
      injMask  <= testMask;
    end else if (injHit) begin
      injArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeBits <= '0;
    else causeBits <= (causeBits & ~causeClr) | (rdValid ? rdErr : '0);
  end

  assign irq = |(causeBits & intEn);

  // R1
  scrub_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    scrubDone |=> scrubDone);

  // R8
  inj_oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (injArmed && wrEn && scrubDone && memSel == injSel && !testWr) |=> !injArmed);

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((causeBits & ($past(causeBits) & ~$past(causeClr)))
              == ($past(causeBits) & ~$past(causeClr))));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (causeBits != '0));
endmodule

// File: rtl/protMemSet.sv
module protMemSet
  import protMemPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    memSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [6:0]    addr,
  input  logic [31:0]   wrData,
  input  logic [3:0]    wrFmask,
  output logic          rdValid,
  output logic [31:0]   rdData,
  output logic [3:0]    rdFmask,
  output logic [3:0]    rdErr,
  input  logic          testWr,
  input  logic [1:0]    testSel,
  input  logic [7:0]    testMask,
  output logic          injArmed,
  input  logic [3:0]    causeClr,
  input  logic [3:0]    intEn,
  output logic [3:0]    causeBits,
  output logic          irq,
  output logic          scrubDone
);
  memStrobe_t strobe;

  protMemCtrl #(.ScrubDepth(128)) uCtrl (
    .clk(clk), .rstN(rstN), .memSel(memSel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .testWr(testWr), .testSel(testSel), .testMask(testMask), .causeClr(causeClr),
    .intEn(intEn), .rdValid(rdValid), .rdErr(rdErr), .strobe(strobe),
    .scrubDone(scrubDone), .injArmed(injArmed), .causeBits(causeBits), .irq(irq)
  );

  protMemDatapath #(.CntDepth(64), .FiltDepth(128)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrFmask(wrFmask),
    .rdValid(rdValid), .rdData(rdData), .rdFmask(rdFmask), .rdErr(rdErr)
  );

  // R1
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!scrubDone && rdEn) |=> !rdValid);
endmodule

// File: tb/sim_protMemSet.sv
`timescale 1ns/1ps
module sim_protMemSet;
  logic clk = 1'b0;
  logic rstN;
  logic [1:0] memSel;
  logic wrEn, rdEn;
  logic [6:0] addr;
  logic [31:0] wrData;
  logic [3:0] wrFmask;
  logic rdValid;
  logic [31:0] rdData;
  logic [3:0] rdFmask, rdErr;
  logic testWr;
  logic [1:0] testSel;
  logic [7:0] testMask;
  logic injArmed;
  logic [3:0] causeClr, intEn, causeBits;
  logic irq, scrubDone;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  protMemSet u0 (
    .clk(clk), .rstN(rstN), .memSel(memSel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .wrFmask(wrFmask), .rdValid(rdValid), .rdData(rdData),
    .rdFmask(rdFmask), .rdErr(rdErr), .testWr(testWr), .testSel(testSel),
    .testMask(testMask), .injArmed(injArmed), .causeClr(causeClr), .intEn(intEn),
    .causeBits(causeBits), .irq(irq), .scrubDone(scrubDone)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [6:0]  adr;
    logic [31:0] data;
    logic [3:0]  fmask;
    logic [7:0]  imask;
    logic [3:0]  expErr;
  } vec_t;

  localparam int NumVec = 10;
  localparam vec_t Vecs [NumVec] = '{
    '{2'd0, 7'd5,   32'hA5A5_1234, 4'h0, 8'h00, 4'b0000},
    '{2'd1, 7'd100, 32'hDEAD_BEEF, 4'h0, 8'h00, 4'b0000},
    '{2'd2, 7'd127, 32'h0F0F_F0F0, 4'h9, 8'h00, 4'b0000},
    '{2'd0, 7'd63,  32'hFFFF_FFFF, 4'h0, 8'h01, 4'b0001},
    '{2'd0, 7'd10,  32'h1357_9BDF, 4'h0, 8'h80, 4'b0001},
    '{2'd0, 7'd11,  32'h0000_0001, 4'h0, 8'h03, 4'b0010},
    '{2'd1, 7'd0,   32'h8000_0001, 4'h0, 8'h04, 4'b0100},
    '{2'd2, 7'd1,   32'h1234_5678, 4'h6, 8'h10, 4'b1000},
    '{2'd2, 7'd2,   32'h0000_0000, 4'h0, 8'h01, 4'b1000},
    '{2'd0, 7'd20,  32'h0000_0040, 4'h0, 8'h40, 4'b0001}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] s, input logic [6:0] a, input logic [31:0] d,
                         input logic [3:0] m);
    @(negedge clk);
    memSel = s; addr = a; wrData = d; wrFmask = m; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] s, input logic [6:0] a);
    @(negedge clk);
    memSel = s; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic arm(input logic [1:0] s, input logic [7:0] m);
    @(negedge clk);
    testSel = s; testMask = m; testWr = 1'b1;
    @(negedge clk);
    testWr = 1'b0;
  endtask

  task automatic clrCause(input logic [3:0] m);
    @(negedge clk);
    causeClr = m;
    @(negedge clk);
    causeClr = 4'h0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int n;
    rstN = 1'b0; memSel = 2'd3; wrEn = 0; rdEn = 0; addr = '0; wrData = '0; wrFmask = '0;
    testWr = 0; testSel = '0; testMask = '0; causeClr = '0; intEn = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {scrubDone, injArmed, causeBits, irq}, '0);
    rstN = 1'b1;
    memSel = 2'd0; addr = 7'd0; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    n = 1;
    // R1 read during scrub is blocked
    check("R1 no rdValid before scrub done", rdValid, 0);
    while (!scrubDone) begin
      @(negedge clk);
      n++;
    end
    check("R1 scrub length", n, 128);

    // R2 scrubbed contents
    doRead(2'd0, 7'd0);   check("R2 counter 0", {rdErr, rdFmask, rdData}, '0);
    doRead(2'd0, 7'd63);  check("R2 counter 63", {rdErr, rdFmask, rdData}, '0);
    doRead(2'd1, 7'd0);   check("R2 filter 0", {rdErr, rdFmask, rdData}, '0);
    doRead(2'd1, 7'd127); check("R2 filter 127", {rdErr, rdFmask, rdData}, '0);
    doRead(2'd2, 7'd64);  check("R2 flex 64", {rdErr, rdFmask, rdData}, '0);
    @(negedge clk);
    check("R2 no cause after scrub reads", causeBits, 0);

    // Vector table: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NumVec; i++) begin
      clrCause(4'hF);
      if (Vecs[i].imask != 8'h00) arm(Vecs[i].sel, Vecs[i].imask);
      doWrite(Vecs[i].sel, Vecs[i].adr, Vecs[i].data, Vecs[i].fmask);
      check("R9 no cause at write", causeBits, 0);
      doRead(Vecs[i].sel, Vecs[i].adr);
      check("R3 rdValid", rdValid, 1);
      if (!Vecs[i].expErr[1])
        check("R3/R4/R6 data", {rdFmask, rdData},
              {(Vecs[i].sel == 2'd2) ? Vecs[i].fmask : 4'h0, Vecs[i].data});
      check("R4/R5/R6/R7 rdErr", rdErr, Vecs[i].expErr);
      @(negedge clk);
      check("R10 cause latched", causeBits, Vecs[i].expErr);
    end

    // R8 one-shot and selection
    clrCause(4'hF);
    arm(2'd1, 8'h01);
    check("R8 armed", injArmed, 1);
    doWrite(2'd0, 7'd30, 32'hCAFE_0001, 4'h0);
    check("R8 other store keeps armed", injArmed, 1);
    doRead(2'd0, 7'd30);
    check("R8 other store clean", {rdErr, rdData}, {4'b0000, 32'hCAFE_0001});
    doWrite(2'd1, 7'd30, 32'h0BAD_F00D, 4'h0);
    check("R8 armed cleared", injArmed, 0);
    doRead(2'd1, 7'd30);
    check("R8 injected filter fault", rdErr, 4'b0100);
    doWrite(2'd1, 7'd31, 32'h1111_2222, 4'h0);
    doRead(2'd1, 7'd31);
    check("R8 second write clean", rdErr, 4'b0000);
    doWrite(2'd1, 7'd30, 32'h0BAD_F00D, 4'h0);
    doRead(2'd1, 7'd30);
    check("R8 rewrite clears fault", {rdErr, rdData}, {4'b0000, 32'h0BAD_F00D});
    @(negedge clk);
    // R10 sticky across clean reads
    check("R10 sticky", causeBits, 4'b0100);

    // R10 clear and detection on the same edge: set wins
    arm(2'd1, 8'h02);
    doWrite(2'd1, 7'd40, 32'h7777_0000, 4'h0);
    @(negedge clk);
    memSel = 2'd1; addr = 7'd40; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; causeClr = 4'b0100;
    @(negedge clk);
    causeClr = 4'h0;
    check("R10 set wins over clear", causeBits[2], 1);
    clrCause(4'b0100);
    check("R10 clear", causeBits, 0);

    // R11 interrupt gating
    arm(2'd2, 8'h10);
    doWrite(2'd2, 7'd50, 32'h0000_00FF, 4'h3);
    doRead(2'd2, 7'd50);
    check("R7 mask parity fault", rdErr, 4'b1000);
    @(negedge clk);
    intEn = 4'b0000; #1;
    check("R11 irq disabled", irq, 0);
    intEn = 4'b0111; #1;
    check("R11 irq other enables", irq, 0);
    intEn = 4'b1000; #1;
    check("R11 irq enabled", irq, 1);
    clrCause(4'b1000);
    check("R11 irq after clear", irq, 0);

    finishRun();
  end
endmodule